// File: doc/BRIEF.md
# Packed Multi-Slot Audio Serial Port

A transmit-only serial audio port. Each frame carries six audio channels in a packed layout. A frame is two halves. Each half holds three 20-bit slots followed by a short idle gap. A single frame clock, in the style of a left/right word clock, marks the whole multichannel group: it sits at its active level for the left half and at the opposite level for the right half. Parallel samples arrive one at a time over a valid/ready input. They go into the slots strictly in arrival order, left slots first and then right slots, and are shifted out MSB first.

The bit clock comes from one of two sources. It can be made from the system clock by a programmable even divisor, or it can be taken from an input pin, in which case the pin is synchronised and its edges are detected in the system clock domain. The frame clock can be generated by the port (master) or taken from a pin (slave). A configuration input picks which bit-clock edge drives data and frame clock. A second configuration input picks the frame clock's active level. A narrow mode places 16-bit samples at the top of each slot. All configuration inputs are static and change only while reset is held.

Top module: `pkd_tdm_tx`

## Requirements
- R1: With `bclk_ext_i`=0 and an even `div_i` of at least 2, `bclk_o` toggles every `div_i`/2 system clocks. With `div_i` equal to 0, `bclk_o` stays where it is and no bits are sent.
- R2: With `bclk_ext_i`=1, all bit timing follows the synchronised edges of `ext_bclk_i`, `bclk_o` is held at 0, and `div_i` has no effect.
- R3: With `drive_rise_i`=1, `sdata_o` and `fs_o` change only after a rising bit-clock edge and are meant to be sampled on the falling edge. With `drive_rise_i`=0 the two edges swap roles.
- R4: A frame is 128 bit positions. Positions 0-19, 20-39 and 40-59 carry left slots 0, 1 and 2. Positions 64-83, 84-103 and 104-123 carry right slots 0, 1 and 2. Positions 60-63 and 124-127 drive 0. Each slot takes the next accepted sample in order.
- R5: With `narrow_i`=0, a slot sends `s_data_i[19:0]` MSB first. With `narrow_i`=1, a slot sends `s_data_i[15:0]` MSB first in its first 16 positions, followed by four 0 bits.
- R6: In master mode (`fs_master_i`=1), `fs_o` is at the active level (1 when `fs_act_high_i`=1, 0 otherwise) during positions 127 and 0-62, and at the inactive level during positions 63-126. Its active edge therefore recurs every 128 bit clocks.
- R7: In slave mode (`fs_master_i`=0), `fs_o` is held at 0. After reset the port sends 0 and consumes no sample until `ext_fs_i`, sampled on the sampling edge, first moves to the active level. Each such move makes the next bit position 0 of a frame.
- R8: If no sample is held when a slot begins, that slot sends 0 bits and `underflow_o` is high for exactly one system clock. While samples keep up, `underflow_o` stays low.
- R9: The input holds one sample. `s_ready_o` is 1 when that holding stage is empty, and a sample is taken on a clock with `s_valid_i` and `s_ready_o` both 1.
- R10: Right after reset, `sdata_o`=0, `bclk_o`=0, `underflow_o`=0 and `s_ready_o`=1. In master mode `fs_o` is at its active level, and in slave mode it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_ext_i | input | 1 | 1: bit clock from `ext_bclk_i`; 0: internal divider |
| div_i | input | DIV_W | Even system-clock divisor for the internal bit clock; 0 stops it |
| drive_rise_i | input | 1 | 1: drive on rising bit-clock edge; 0: drive on falling edge |
| fs_master_i | input | 1 | 1: generate the frame clock; 0: follow `ext_fs_i` |
| fs_act_high_i | input | 1 | Active level of the frame clock |
| narrow_i | input | 1 | 1: 16-bit samples left-justified in each slot |
| ext_bclk_i | input | 1 | External bit clock |
| ext_fs_i | input | 1 | External frame clock (slave mode) |
| s_valid_i | input | 1 | Sample valid |
| s_data_i | input | SLOT_W | Sample data |
| s_ready_o | output | 1 | Holding stage empty |
| bclk_o | output | 1 | Internally generated bit clock |
| fs_o | output | 1 | Frame clock in master mode |
| sdata_o | output | 1 | Serial data |
| underflow_o | output | 1 | One-clock pulse for a slot started without a sample |

## Verification
The bench builds the port with its default parameters: 20-bit slots, three slots per half, a 4-bit gap, an 8-bit divisor and two synchroniser stages. Every configuration therefore exercises the full 128-position frame, including both gaps and the left/right boundary. It sweeps all eight combinations of drive edge, frame-clock polarity and sample width at divisor 2. Further runs use divisor 4, an external bit clock, and slave mode at divisor 8 with a late external frame clock. Each run feeds eighteen samples and then starves the input, so the last fed slot, the first starved slot and the count of underflow pulses all fall inside the checked window.

// File: rtl/pkd_tdm_pkg.sv
package pkd_tdm_pkg;

  localparam int unsigned SLOT_W_DEF   = 20;
  localparam int unsigned SLOTS_DEF    = 3;
  localparam int unsigned GAP_W_DEF    = 4;
  localparam int unsigned NARROW_W_DEF = 16;

  // frame clock level for a bit position: active through the first half,
  // moved one bit early at both half boundaries
  function automatic logic fs_level(logic first_half, logic half_end);
    return first_half ^ half_end;
  endfunction

endpackage

// File: rtl/ptx_sync.sv
module ptx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= 1'b0;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_chain
      logic [STAGES-1:0] q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= {q_q[STAGES-2:0], d_i};
      end
      assign q_o = q_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ptx_bclk_gen.sv
module ptx_bclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_bclk_i,
  input  logic             drive_rise_i,
  output logic             bclk_o,
  output logic             drive_en_o,
  output logic             sample_en_o
);

  localparam int unsigned HALF_W = DIV_W - 1;

  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt_q;
  logic              bclk_q;
  logic              ext_prev_q;
  logic              int_run;
  logic              int_tgl;
  logic              rise;
  logic              fall;

  assign half    = div_i[DIV_W-1:1];
  assign int_run = !ext_sel_i && (half != '0);
  assign int_tgl = int_run && (cnt_q >= half - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      bclk_q     <= 1'b0;
      ext_prev_q <= 1'b0;
    end else begin
      ext_prev_q <= ext_bclk_i;
      if (!int_run) begin
        cnt_q <= '0;
        if (ext_sel_i) bclk_q <= 1'b0;
      end else if (int_tgl) begin
        cnt_q  <= '0;
        bclk_q <= ~bclk_q;
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end

  always_comb begin
    if (ext_sel_i) begin
      rise = ext_bclk_i & ~ext_prev_q;
      fall = ~ext_bclk_i & ext_prev_q;
    end else begin
      rise = int_tgl & ~bclk_q;
      fall = int_tgl & bclk_q;
    end
  end

  assign bclk_o      = bclk_q;
  assign drive_en_o  = drive_rise_i ? rise : fall;
  assign sample_en_o = drive_rise_i ? fall : rise;

  a_r1_stopped_divider: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_sel_i && div_i[DIV_W-1:1] == '0) |=> $stable(bclk_o));

  a_r2_ext_bclk_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sel_i |=> !bclk_o);

  a_r3_single_edge_role: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drive_en_o && sample_en_o));

endmodule

// File: rtl/ptx_framer.sv
module ptx_framer
  import pkd_tdm_pkg::*;
#(
  parameter int unsigned SLOT_W = SLOT_W_DEF,
  parameter int unsigned SLOTS  = SLOTS_DEF,
  parameter int unsigned GAP_W  = GAP_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_en_i,
  input  logic sample_en_i,
  input  logic fs_master_i,
  input  logic fs_act_high_i,
  input  logic fs_ext_i,
  output logic fs_o,
  output logic load_o
);

  localparam int unsigned MAXLEN = (SLOT_W > GAP_W) ? SLOT_W : GAP_W;
  localparam int unsigned BW     = $clog2(MAXLEN + 1);
  localparam int unsigned SIW    = $clog2(SLOTS + 1);
  localparam logic [SIW-1:0] GAP_IDX   = SIW'(SLOTS);
  localparam logic [BW-1:0]  SLOT_LAST = BW'(SLOT_W - 1);
  localparam logic [BW-1:0]  GAP_LAST  = BW'(GAP_W - 1);

  logic           half_q, half_n;
  logic [SIW-1:0] slot_q, slot_n;
  logic [BW-1:0]  bit_q, bit_n;
  logic           last_bit;
  logic           next_half_end;
  logic           synced_q;
  logic           fs_on_q;
  logic           fs_on;
  logic           fs_lvl_q;
  logic           run;
  logic           resync;

  always_comb begin
    last_bit = (slot_q == GAP_IDX) ? (bit_q == GAP_LAST) : (bit_q == SLOT_LAST);
    half_n   = half_q;
    slot_n   = slot_q;
    bit_n    = bit_q + BW'(1);
    if (last_bit) begin
      bit_n = '0;
      if (slot_q == GAP_IDX) begin
        slot_n = '0;
        half_n = ~half_q;
      end else begin
        slot_n = slot_q + SIW'(1);
      end
    end
    next_half_end = (slot_n == GAP_IDX) && (bit_n == GAP_LAST);
  end

  assign run    = fs_master_i | synced_q;
  assign fs_on  = (fs_ext_i == fs_act_high_i);
  assign resync = sample_en_i & ~fs_master_i & fs_on & ~fs_on_q;

  // reset state is the last bit of the right half, so the next drive edge opens a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q   <= 1'b1;
      slot_q   <= GAP_IDX;
      bit_q    <= GAP_LAST;
      synced_q <= 1'b0;
      fs_on_q  <= 1'b0;
      fs_lvl_q <= 1'b1;
    end else begin
      if (sample_en_i) fs_on_q <= fs_on;
      if (resync) begin
        synced_q <= 1'b1;
        half_q   <= 1'b1;
        slot_q   <= GAP_IDX;
        bit_q    <= GAP_LAST;
        fs_lvl_q <= 1'b1;
      end else if (drive_en_i && run) begin
        half_q   <= half_n;
        slot_q   <= slot_n;
        bit_q    <= bit_n;
        fs_lvl_q <= fs_level(~half_n, next_half_end);
      end
    end
  end

  assign load_o = drive_en_i & run & (slot_n != GAP_IDX) & (bit_n == '0);
  assign fs_o   = fs_master_i ? (fs_lvl_q == fs_act_high_i) : 1'b0;

  a_r4_slot_index_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= GAP_IDX);

  a_r4_gap_bit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == GAP_IDX) |-> (bit_q <= GAP_LAST));

  a_r6_fs_on_drive_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_master_i && !drive_en_i) |=> $stable(fs_o));

  a_r7_idle_until_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !resync) |=> (slot_q == GAP_IDX && bit_q == GAP_LAST));

endmodule

// File: rtl/ptx_slot_shifter.sv
module ptx_slot_shifter
  import pkd_tdm_pkg::*;
#(
  parameter int unsigned SLOT_W   = SLOT_W_DEF,
  parameter int unsigned NARROW_W = NARROW_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              narrow_i,
  input  logic              s_valid_i,
  input  logic [SLOT_W-1:0] s_data_i,
  output logic              s_ready_o,
  input  logic              drive_en_i,
  input  logic              load_i,
  output logic              sdata_o,
  output logic              underflow_o
);

  logic [SLOT_W-1:0] hold_q;
  logic              hold_vld_q;
  logic [SLOT_W-1:0] shreg_q;
  logic              uf_q;
  logic [SLOT_W-1:0] narrow_word;
  logic [SLOT_W-1:0] slot_word;
  logic              take;
  logic              accept;

  generate
    if (SLOT_W > NARROW_W) begin : g_pad
      assign narrow_word = {hold_q[NARROW_W-1:0], {(SLOT_W-NARROW_W){1'b0}}};
    end else begin : g_nopad
      assign narrow_word = hold_q;
    end
  endgenerate

  assign slot_word = narrow_i ? narrow_word : hold_q;
  assign take      = drive_en_i & load_i & hold_vld_q;
  assign accept    = s_valid_i & ~hold_vld_q;
  assign s_ready_o = ~hold_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      shreg_q    <= '0;
      uf_q       <= 1'b0;
    end else begin
      uf_q <= 1'b0;
      if (take) hold_vld_q <= 1'b0;
      if (accept) begin
        hold_vld_q <= 1'b1;
        hold_q     <= s_data_i;
      end
      if (drive_en_i && load_i) begin
        shreg_q <= hold_vld_q ? slot_word : '0;
        uf_q    <= ~hold_vld_q;
      end else if (drive_en_i) begin
        shreg_q <= {shreg_q[SLOT_W-2:0], 1'b0};
      end
    end
  end

  assign sdata_o     = shreg_q[SLOT_W-1];
  assign underflow_o = uf_q;

  a_r8_underflow_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> !underflow_o);

  a_r9_held_sample_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_vld_q && !take) |=> (hold_vld_q && $stable(hold_q)));

  a_r3_data_on_drive_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_en_i |=> $stable(sdata_o));

endmodule

// File: rtl/pkd_tdm_tx.sv
module pkd_tdm_tx
  import pkd_tdm_pkg::*;
#(
  parameter int unsigned SLOT_W      = SLOT_W_DEF,
  parameter int unsigned SLOTS       = SLOTS_DEF,
  parameter int unsigned GAP_W       = GAP_W_DEF,
  parameter int unsigned NARROW_W    = NARROW_W_DEF,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_ext_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              drive_rise_i,
  input  logic              fs_master_i,
  input  logic              fs_act_high_i,
  input  logic              narrow_i,
  input  logic              ext_bclk_i,
  input  logic              ext_fs_i,
  input  logic              s_valid_i,
  input  logic [SLOT_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              bclk_o,
  output logic              fs_o,
  output logic              sdata_o,
  output logic              underflow_o
);

  logic ext_bclk_s;
  logic ext_fs_s;
  logic drive_en;
  logic sample_en;
  logic load;

  ptx_sync #(.STAGES(SYNC_STAGES)) u_sync_bclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_bclk_i),
    .q_o   (ext_bclk_s)
  );

  ptx_sync #(.STAGES(SYNC_STAGES)) u_sync_fs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_fs_i),
    .q_o   (ext_fs_s)
  );

  ptx_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_sel_i   (bclk_ext_i),
    .div_i       (div_i),
    .ext_bclk_i  (ext_bclk_s),
    .drive_rise_i(drive_rise_i),
    .bclk_o      (bclk_o),
    .drive_en_o  (drive_en),
    .sample_en_o (sample_en)
  );

  ptx_framer #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .GAP_W(GAP_W)) u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .drive_en_i   (drive_en),
    .sample_en_i  (sample_en),
    .fs_master_i  (fs_master_i),
    .fs_act_high_i(fs_act_high_i),
    .fs_ext_i     (ext_fs_s),
    .fs_o         (fs_o),
    .load_o       (load)
  );

  ptx_slot_shifter #(.SLOT_W(SLOT_W), .NARROW_W(NARROW_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .narrow_i   (narrow_i),
    .s_valid_i  (s_valid_i),
    .s_data_i   (s_data_i),
    .s_ready_o  (s_ready_o),
    .drive_en_i (drive_en),
    .load_i     (load),
    .sdata_o    (sdata_o),
    .underflow_o(underflow_o)
  );

endmodule

// File: tb/pkd_tdm_tx_tb.sv
module pkd_tdm_tx_tb;

  localparam int NS    = 18;
  localparam int FRAME = 128;
  localparam int EXT_H = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bclk_ext_i = 1'b0;
  logic [7:0] div_i = '0;
  logic       drive_rise_i = 1'b0;
  logic       fs_master_i = 1'b1;
  logic       fs_act_high_i = 1'b1;
  logic       narrow_i = 1'b0;
  logic       ext_bclk_i = 1'b0;
  logic       ext_fs_i = 1'b0;
  logic       s_valid_i = 1'b0;
  logic [19:0] s_data_i = '0;
  logic       s_ready_o, bclk_o, fs_o, sdata_o, underflow_o;

  always #5 clk_i = ~clk_i;

  pkd_tdm_tx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bclk_ext_i(bclk_ext_i), .div_i(div_i),
    .drive_rise_i(drive_rise_i), .fs_master_i(fs_master_i),
    .fs_act_high_i(fs_act_high_i), .narrow_i(narrow_i), .ext_bclk_i(ext_bclk_i),
    .ext_fs_i(ext_fs_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .s_ready_o(s_ready_o), .bclk_o(bclk_o), .fs_o(fs_o), .sdata_o(sdata_o),
    .underflow_o(underflow_o)
  );

  int vecs = 0;
  int errs = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] dat(int k);
    return 20'((k * 32'h3a5c7 + 32'h9b1) ^ (k << 7));
  endfunction

  function automatic bit lvl(int b);
    return (b <= 62) || (b == 127);
  endfunction

  bit c_ext, c_rise, c_act, c_s16, c_master;
  int c_div;

  function automatic bit exp_bit(int f, int b);
    int half, off, slot, j, k;
    logic [19:0] d;
    half = b / 64;
    off  = b % 64;
    if (off >= 60) return 1'b0;
    slot = off / 20;
    j    = off % 20;
    k    = f * 6 + half * 3 + slot;
    if (k >= NS) return 1'b0;
    d = dat(k);
    if (c_s16) return (j < 16) ? d[15-j] : 1'b0;
    return d[19-j];
  endfunction

  // producer
  bit prod_en = 0;
  bit pend = 0;
  int n = 0;
  always @(negedge clk_i) begin
    if (prod_en) begin
      if (pend) n++;
      if (n < NS) begin
        s_valid_i = 1'b1;
        s_data_i  = dat(n);
        pend      = s_ready_o;
      end else begin
        s_valid_i = 1'b0;
        pend      = 1'b0;
      end
    end else begin
      s_valid_i = 1'b0;
      pend      = 1'b0;
    end
  end

  // monitor
  bit mon_en = 0;
  bit oc_prev, bo_prev, tgl_seen, on_prev, aligned, done;
  int half_cnt, uf_cnt, b, f, bp, ecnt;

  always @(negedge clk_i) begin
    if (mon_en) begin
      bit oc, on, ref_fs;
      oc = c_ext ? ext_bclk_i : bclk_o;
      if (underflow_o) uf_cnt++;
      if (!c_ext) begin
        half_cnt++;
        if (bclk_o != bo_prev) begin
          if (tgl_seen) chk(half_cnt == c_div / 2, "R1 bclk half period", half_cnt, c_div / 2);
          tgl_seen = 1;
          half_cnt = 0;
        end
        bo_prev = bclk_o;
      end else begin
        chk(bclk_o == 1'b0, "R2 bclk_o held low with external clock", bclk_o, 0);
      end
      if (oc != oc_prev && !done) begin
        if (oc != c_rise) begin
          // sampling edge (R3)
          ref_fs = c_master ? fs_o : ext_fs_i;
          on = (ref_fs == c_act);
          if (on && !on_prev) begin
            if (aligned) chk(b == 126, "R6 frame clock period", b, 126);
            b = 127;
            aligned = 1;
          end else if (aligned) begin
            b = (b + 1) % FRAME;
            if (b == 0) f++;
          end
          on_prev = on;
          if (!c_master) chk(fs_o == 1'b0, "R7 fs_o low in slave", fs_o, 0);
          if (!aligned && !c_master) begin
            chk(sdata_o == 1'b0, "R7 idle data before sync", sdata_o, 0);
            chk(s_ready_o == 1'b0, "R7 no sample consumed before sync", s_ready_o, 0);
          end
          if (aligned) begin
            if (f >= 4) done = 1;
            else begin
              int k;
              k = f * 6 + (b / 64) * 3 + (b % 64) / 20;
              chk(sdata_o == exp_bit(f, b), $sformatf("R4 R5 frame %0d pos %0d", f, b),
                  sdata_o, exp_bit(f, b));
              if (c_master)
                chk(fs_o == (lvl(b) ? c_act : !c_act), $sformatf("R6 fs level pos %0d", b),
                    fs_o, lvl(b) ? c_act : !c_act);
              if ((b % 64) < 60 && k == NS - 1 && (b % 20) == 19)
                chk(uf_cnt == 0, "R8 no underflow while fed", uf_cnt, 0);
              if ((b % 64) == 0 && k == NS)
                chk(uf_cnt >= 1, "R8 underflow on starved slot", uf_cnt, 1);
            end
          end
        end else if (!c_master) begin
          bp = (bp + 1) % FRAME;
          ext_fs_i = lvl(bp) ? c_act : !c_act;
        end
      end
      oc_prev = oc;
      if (c_ext) begin
        ecnt++;
        if (ecnt == EXT_H) begin
          ecnt = 0;
          ext_bclk_i = ~ext_bclk_i;
        end
      end
    end
  end

  task automatic run_cfg(input bit ext, input int div, input bit rise, input bit act,
                         input bit s16, input bit master);
    int guard;
    @(negedge clk_i);
    mon_en = 0; prod_en = 0; rst_ni = 1'b0;
    c_ext = ext; c_div = div; c_rise = rise; c_act = act; c_s16 = s16; c_master = master;
    bclk_ext_i = ext; drive_rise_i = rise; fs_act_high_i = act; narrow_i = s16;
    fs_master_i = master; div_i = '0;
    ext_bclk_i = 1'b0; ext_fs_i = !act; ecnt = 0; bp = 70;
    n = 0; aligned = 0; done = 0; b = 0; f = master ? 0 : -1;
    on_prev = master; oc_prev = 0; bo_prev = 0; tgl_seen = 0; half_cnt = 0; uf_cnt = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sdata_o == 1'b0, "R10 reset sdata", sdata_o, 0);
    chk(bclk_o == 1'b0, "R10 reset bclk", bclk_o, 0);
    chk(underflow_o == 1'b0, "R10 reset underflow", underflow_o, 0);
    chk(s_ready_o == 1'b1, "R10 reset ready", s_ready_o, 1);
    chk(fs_o == (master ? act : 1'b0), "R10 reset fs level", fs_o, master ? act : 1'b0);
    prod_en = 1;
    repeat (6) @(negedge clk_i);
    chk(s_ready_o == 1'b0, "R9 one sample held", s_ready_o, 0);
    chk(bclk_o == 1'b0, "R1 stopped with divisor 0", bclk_o, 0);
    chk(sdata_o == 1'b0, "R1 no bits with divisor 0", sdata_o, 0);
    div_i = 8'(div);
    mon_en = 1;
    guard = 0;
    while (!done && guard < 30000) begin
      @(negedge clk_i);
      guard++;
    end
    chk(done, "R4 frames observed", done, 1);
    chk(uf_cnt == 7, "R8 one pulse per starved slot", uf_cnt, 7);
    chk(n == NS, "R9 all samples accepted", n, NS);
    mon_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) run_cfg(1'b0, 2, i[0], i[1], i[2], 1'b1);
    run_cfg(1'b0, 4, 1'b1, 1'b1, 1'b0, 1'b1);
    run_cfg(1'b1, 2, 1'b0, 1'b0, 1'b0, 1'b1);
    run_cfg(1'b0, 8, 1'b1, 1'b1, 1'b1, 1'b0);
    run_cfg(1'b0, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    errs++;
    $display("FAIL watchdog R4 act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule